// File: doc/BRIEF.md
# Picture Unit Frame Timing Generator

This block produces the raster timing for a tile-based picture unit. A dot counter steps through the dot positions of each scanline, and a line counter steps through the scanlines of each frame. Both move only on cycles where a one-cycle advance enable is high, so a fast system clock can drive the block at the lower dot rate. Decode logic turns the two counters into three region flags. The first marks the visible rendering window. The second marks vertical blanking. The third marks the two dummy lines that bracket blanking.

The block also holds a vertical-blank flag and exposes it to the host processor through a status byte. The flag is set when blanking begins and cleared on the pre-render line. A host read of the status byte also clears it. An interrupt request line is raised while the flag is set and a control bit permits it. There is no streaming data path: the advance enable, read strobe and control bit are plain level or strobe pins with no handshake. The status byte is a combinational view of the flag.

Top module: `ppu_frame_timer`

## Requirements
- R1: After reset the dot position is 0, the line is 0, the status byte is 0x00 and the interrupt request is low.
- R2: While `dot_en` is low at a clock edge, the dot and line positions do not change.
- R3: The dot position counts from 0 to 340. An advance from dot 340 returns it to 0 and moves the line up by one. An advance from line 261, dot 340 returns the position to line 0, dot 0.
- R4: `render_active` is high exactly when the line is 0 to 239 and the dot is 1 to 256.
- R5: `in_vblank` is high on lines 241 to 260. `in_dummy` is high on lines 240 and 261. Both are low on lines 0 to 239.
- R6: The vertical-blank flag is set by the advance from line 241, dot 0 into dot 1. Nothing else sets it, so it stays clear for the rest of blanking after it has been read.
- R7: `nmi_req` is high exactly while the vertical-blank flag and `nmi_enable` are both high, and it follows `nmi_enable` without waiting for a clock edge.
- R8: `status_data` bit 7 shows the flag and bits 6 to 0 read zero. A clock edge with `status_rd` high clears the flag, except when that edge is also the setting edge of R6; in that case the flag ends up set.
- R9: The flag is cleared by the advance from line 261, dot 0 into dot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | One-cycle advance enable for the dot counter |
| nmi_enable | input | 1 | Control bit that permits the interrupt request |
| status_rd | input | 1 | Host read strobe for the status byte; clears the flag |
| status_data | output | 8 | Status byte: bit 7 is the vertical-blank flag, the other bits are zero |
| dot_x | output | 9 | Current dot position within the line |
| line_y | output | 9 | Current scanline within the frame |
| render_active | output | 1 | High inside the visible pixel window |
| in_vblank | output | 1 | High on vertical-blanking lines |
| in_dummy | output | 1 | High on the two dummy lines |
| nmi_req | output | 1 | Interrupt request, active high |

## Verification
The counters are first driven with the enable held low and then with it pulsed continuously. This separates a counter that free-runs from one that respects the enable. The render window is probed on both sides of each edge, at dots 0, 1, 256 and 257 and across lines 239 and 240, which catches off-by-one decode errors. The flag is exercised with a host read that lands on the setting edge, with `nmi_enable` toggled while the flag is set, with reads before and after the flag clears, and by carrying the flag through to the pre-render line. Together these tell the set-priority, read-clear, no-retrigger and pre-render-clear behaviours apart. A full frame wrap and a second blanking entry confirm that the line counter returns to zero.

// File: rtl/ppu_timing_pkg.sv
package ppu_timing_pkg;
  // Region flags decoded from the raster position.
  typedef struct packed {
    logic render;
    logic vblank;
    logic dummy;
  } region_t;
endpackage

// File: rtl/ppu_dot_line_counter.sv
module ppu_dot_line_counter #(
  parameter int DOTS   = 341,
  parameter int LINES  = 262,
  parameter int DOT_W  = 9,
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  output logic [DOT_W-1:0]  dot_x,
  output logic [LINE_W-1:0] line_y
);
  localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_x  <= '0;
      line_y <= '0;
    end else if (dot_en) begin
      if (dot_x == LAST_DOT) begin
        dot_x  <= '0;
        line_y <= (line_y == LAST_LINE) ? '0 : line_y + 1'b1;
      end else begin
        dot_x <= dot_x + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ppu_region_decode.sv
module ppu_region_decode
  import ppu_timing_pkg::*;
#(
  parameter int VIS_DOTS  = 256,
  parameter int VIS_LINES = 240,
  parameter int SET_LINE  = 241,
  parameter int CLR_LINE  = 261,
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9
) (
  input  logic [DOT_W-1:0]  dot_x,
  input  logic [LINE_W-1:0] line_y,
  output region_t           region
);
  logic line_visible;
  logic dot_visible;

  always_comb begin
    line_visible  = (line_y < LINE_W'(VIS_LINES));
    dot_visible   = (dot_x >= DOT_W'(1)) && (dot_x <= DOT_W'(VIS_DOTS));
    region.render = line_visible && dot_visible;
    region.vblank = (line_y >= LINE_W'(SET_LINE)) && (line_y < LINE_W'(CLR_LINE));
    region.dummy  = (line_y == LINE_W'(VIS_LINES)) || (line_y == LINE_W'(CLR_LINE));
  end
endmodule

// File: rtl/ppu_vblank_status.sv
module ppu_vblank_status #(
  parameter int SET_LINE = 241,
  parameter int CLR_LINE = 261,
  parameter int FLAG_DOT = 1,
  parameter int DOT_W    = 9,
  parameter int LINE_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  input  logic [DOT_W-1:0]  dot_x,
  input  logic [LINE_W-1:0] line_y,
  input  logic              status_rd,
  input  logic              nmi_enable,
  output logic              vbl_flag,
  output logic              nmi_req
);
  localparam logic [DOT_W-1:0] PRE_DOT = DOT_W'(FLAG_DOT - 1);

  logic set_evt;
  logic clr_evt;

  always_comb begin
    set_evt = dot_en && (dot_x == PRE_DOT) && (line_y == LINE_W'(SET_LINE));
    clr_evt = dot_en && (dot_x == PRE_DOT) && (line_y == LINE_W'(CLR_LINE));
  end

  // The setting edge takes priority over a read on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n)                     vbl_flag <= 1'b0;
    else if (set_evt)               vbl_flag <= 1'b1;
    else if (clr_evt || status_rd)  vbl_flag <= 1'b0;
  end

  assign nmi_req = vbl_flag && nmi_enable;
endmodule

// File: rtl/ppu_frame_timer.sv
module ppu_frame_timer
  import ppu_timing_pkg::*;
#(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int VIS_DOTS        = 256,
  parameter int VIS_LINES       = 240,
  parameter int FLAG_DOT        = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dot_en,
  input  logic       nmi_enable,
  input  logic       status_rd,
  output logic [7:0] status_data,
  output logic [8:0] dot_x,
  output logic [8:0] line_y,
  output logic       render_active,
  output logic       in_vblank,
  output logic       in_dummy,
  output logic       nmi_req
);
  localparam int DOT_W    = $clog2(DOTS_PER_LINE);
  localparam int LINE_W   = $clog2(LINES_PER_FRAME);
  localparam int SET_LINE = VIS_LINES + 1;
  localparam int CLR_LINE = LINES_PER_FRAME - 1;

  logic [DOT_W-1:0]  dot_q;
  logic [LINE_W-1:0] line_q;
  region_t           region;
  logic              vbl_flag;

  ppu_dot_line_counter #(
    .DOTS(DOTS_PER_LINE), .LINES(LINES_PER_FRAME), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .dot_x(dot_q), .line_y(line_q)
  );

  ppu_region_decode #(
    .VIS_DOTS(VIS_DOTS), .VIS_LINES(VIS_LINES), .SET_LINE(SET_LINE),
    .CLR_LINE(CLR_LINE), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_dec (
    .dot_x(dot_q), .line_y(line_q), .region(region)
  );

  ppu_vblank_status #(
    .SET_LINE(SET_LINE), .CLR_LINE(CLR_LINE), .FLAG_DOT(FLAG_DOT),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_vbl (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .dot_x(dot_q), .line_y(line_q),
    .status_rd(status_rd), .nmi_enable(nmi_enable),
    .vbl_flag(vbl_flag), .nmi_req(nmi_req)
  );

  assign dot_x         = 9'(dot_q);
  assign line_y        = 9'(line_q);
  assign render_active = region.render;
  assign in_vblank     = region.vblank;
  assign in_dummy      = region.dummy;
  assign status_data   = {vbl_flag, 7'b0};
endmodule

// File: rtl/ppu_frame_timer_checker.sv
module ppu_frame_timer_checker #(
  parameter int DOTS     = 341,
  parameter int SET_LINE = 241,
  parameter int CLR_LINE = 261,
  parameter int FLAG_DOT = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dot_en,
  input logic       nmi_enable,
  input logic       status_rd,
  input logic [7:0] status_data,
  input logic [8:0] dot_x,
  input logic [8:0] line_y,
  input logic       render_active,
  input logic       in_vblank,
  input logic       in_dummy,
  input logic       nmi_req
);
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> ($stable(dot_x) && $stable(line_y))); // R2

  AST_DOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en && dot_x == 9'(DOTS - 1)) |=> (dot_x == 9'd0)); // R3

  AST_DOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dot_x < 9'(DOTS)); // R3

  AST_RENDER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    render_active |-> (!in_vblank && !in_dummy)); // R5

  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_data[7]) |-> ($past(dot_en) && $past(line_y) == 9'(SET_LINE))); // R6

  AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_data[7]) |-> ($past(status_rd) ||
                               (line_y == 9'(CLR_LINE) && dot_x == 9'(FLAG_DOT)))); // R9

  AST_NMI_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> status_data[7]); // R7

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_data[6:0] == 7'd0); // R8
endmodule

bind ppu_frame_timer ppu_frame_timer_checker #(
  .DOTS(DOTS_PER_LINE), .SET_LINE(VIS_LINES + 1),
  .CLR_LINE(LINES_PER_FRAME - 1), .FLAG_DOT(FLAG_DOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .nmi_enable(nmi_enable),
  .status_rd(status_rd), .status_data(status_data), .dot_x(dot_x),
  .line_y(line_y), .render_active(render_active), .in_vblank(in_vblank),
  .in_dummy(in_dummy), .nmi_req(nmi_req)
);

// File: tb/tb_ppu_frame_timer.sv
`timescale 1ns/1ps
module tb_ppu_frame_timer;
  localparam int DOTS  = 341;
  localparam int LINES = 262;
  localparam int FRAME = DOTS * LINES;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dot_en = 1'b0;
  logic       nmi_enable = 1'b0;
  logic       status_rd = 1'b0;
  logic [7:0] status_data;
  logic [8:0] dot_x, line_y;
  logic       render_active, in_vblank, in_dummy, nmi_req;

  int checks = 0;
  int failures = 0;
  int exp_total = 0;

  always #2 clk = ~clk;

  ppu_frame_timer dut (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .nmi_enable(nmi_enable),
    .status_rd(status_rd), .status_data(status_data), .dot_x(dot_x),
    .line_y(line_y), .render_active(render_active), .in_vblank(in_vblank),
    .in_dummy(in_dummy), .nmi_req(nmi_req)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_pos(string tag);
    check({tag, " dot"}, int'(dot_x), exp_total % DOTS);
    check({tag, " line"}, int'(line_y), exp_total / DOTS);
  endtask

  task automatic run(int n);
    @(negedge clk);
    dot_en = 1'b1;
    repeat (n) @(negedge clk);
    dot_en = 1'b0;
    exp_total = (exp_total + n) % FRAME;
  endtask

  task automatic goto_pos(int ln, int dt);
    int n;
    n = ((ln * DOTS + dt) - exp_total + FRAME) % FRAME;
    if (n > 0) run(n);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pos("R1 reset");
    check("R1 status", int'(status_data), 0);
    check("R1 nmi", int'(nmi_req), 0);
    check("R4 render at dot0", int'(render_active), 0);
  endtask

  task automatic t_hold;
    dot_en = 1'b0;
    repeat (5) @(negedge clk);
    check_pos("R2 hold");
  endtask

  task automatic t_line_walk;
    run(1);   check("R4 dot1", int'(render_active), 1);
    run(255); check("R4 dot256", int'(render_active), 1);
    run(1);   check("R4 dot257", int'(render_active), 0);
    goto_pos(0, 340); check_pos("R3 last dot");
    run(1);   check_pos("R3 line step");
    check("R5 visible vblank", int'(in_vblank), 0);
    check("R5 visible dummy", int'(in_dummy), 0);
  endtask

  task automatic t_visible_edge;
    goto_pos(239, 256); check("R4 line239", int'(render_active), 1);
    goto_pos(240, 1);
    check("R4 line240", int'(render_active), 0);
    check("R5 dummy240", int'(in_dummy), 1);
    check("R5 vblank240", int'(in_vblank), 0);
  endtask

  task automatic t_set_with_read;
    goto_pos(241, 0);
    check("R6 before set", int'(status_data), 0);
    check("R5 vblank241", int'(in_vblank), 1);
    @(negedge clk);
    dot_en = 1'b1; status_rd = 1'b1;
    @(negedge clk);
    dot_en = 1'b0; status_rd = 1'b0;
    exp_total++;
    check("R8 set beats read", int'(status_data), 128);
    check("R7 nmi disabled", int'(nmi_req), 0);
    nmi_enable = 1'b1; #1;
    check("R7 nmi enabled", int'(nmi_req), 1);
    nmi_enable = 1'b0; #1;
    check("R7 nmi gated", int'(nmi_req), 0);
    nmi_enable = 1'b1;
  endtask

  task automatic t_prerender;
    goto_pos(261, 0);
    check("R9 held to 261", int'(status_data), 128);
    check("R5 dummy261", int'(in_dummy), 1);
    check("R5 vblank261", int'(in_vblank), 0);
    run(1);
    check("R9 cleared", int'(status_data), 0);
    check("R7 nmi drops", int'(nmi_req), 0);
    goto_pos(261, 340);
    run(1);
    check_pos("R3 frame wrap");
  endtask

  task automatic t_read_clear;
    goto_pos(241, 1);
    check("R6 set frame2", int'(status_data), 128);
    check("R7 nmi frame2", int'(nmi_req), 1);
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    check("R8 read clears", int'(status_data), 0);
    check("R8 nmi after read", int'(nmi_req), 0);
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    check("R8 read when clear", int'(status_data), 0);
    goto_pos(242, 5);
    check("R6 no retrigger", int'(status_data), 0);
    check("R5 vblank242", int'(in_vblank), 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_line_walk();
    t_visible_edge();
    t_set_with_read();
    t_prerender();
    t_read_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule